// File: doc/BRIEF.md
# Dword stream data scrambler

This block whitens a stream of 32-bit words. Each accepted word leaves the block XORed with a pseudo-random 32-bit mask. The mask comes from a 16-bit linear feedback state that moves forward by 32 bit-steps of the sequence x^16 + x^15 + x^13 + x^4 + 1 for every accepted word. The whole mask is a function of the current state. Bits 31..16 of the mask become the next state.

The input and output are valid/ready streams. A single registered output stage sits between them and adds one cycle of latency. Back-to-back words pass without bubbles.

A synchronous `restart` pulse reloads the word-parallel seed 0xF0F6, so a new frame starts at the head of the sequence. The first mask after a reload is always 0xC2D2768D. XOR is its own inverse, so a second pass with the same alignment restores the original words. The same block therefore serves as both scrambler and descrambler.

Top module: `dword_scrambler`

## Requirements
- R1: During reset and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: The first word accepted after reset is XORed with mask 0xC2D2768D.
- R3: Output word k equals input word k XOR mask k.
  - Each mask holds 32 successive bits of the recurrence s[n+16] = s[n+15] ^ s[n+13] ^ s[n+4] ^ s[n].
  - Bit 0 of the mask is the earliest of these bits.
  - Each mask continues from the last 16 bits of the mask before it.
- R4: Under continuous flow, the mask sequence repeats with a period of exactly 65535 words.
- R5: A `restart` pulse makes the next accepted word use mask 0xC2D2768D. A word accepted in the same cycle as `restart` still uses the current mask.
- R6: When `out_valid`=1 and `out_ready`=0, the following hold:
  - `out_data` and `out_valid` stay unchanged.
  - `in_ready` is 0.
  - No mask is consumed.
- R7: The mask advances only when a word is accepted. Idle cycles between words do not change which mask the next word receives.
- R8: `in_ready` equals `out_ready` OR NOT `out_valid`. An accepted word appears on the output one clock edge later, and one word per cycle can flow.
- R9: Scrambling a frame, restarting, and passing the scrambled words through again returns the original words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Reload the seed so the next accepted word uses the first mask |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take the input word |
| in_data | input | 32 | Input word |
| out_valid | output | 1 | Output register holds a word |
| out_ready | input | 1 | Sink takes the output word |
| out_data | output | 32 | Scrambled word |

## Verification
The condition hardest to reach from the ports is the sequence wrapping back to its first mask. That only happens after 65535 accepted words, so the stimulus holds `in_valid` and `out_ready` high with zero data for 65536 words after a restart. The zero data makes each output equal the raw mask. Every mask is then compared with the first, and only the last one may match. A second hard case is the stall-while-offered window. There the stimulus drops `out_ready` just as a word sits in the output register and keeps a new word offered. This shows that no mask is consumed until the sink frees the register.

// File: rtl/dscr_pkg.sv
package dscr_pkg;
    localparam int unsigned DSCR_STATE_W = 16;
    localparam int unsigned DSCR_WORD_W  = 32;
    // word-parallel seed equivalent to an all-ones serial start
    localparam logic [DSCR_STATE_W-1:0] DSCR_SEED = 16'hF0F6;
    // taps of x^16 + x^15 + x^13 + x^4 + 1 as positions in the 16-bit history
    localparam logic [DSCR_STATE_W-1:0] DSCR_TAPS = 16'hA011;
endpackage

// File: rtl/dscr_mask_gen.sv
module dscr_mask_gen
    import dscr_pkg::*;
#(
    parameter int unsigned STATE_W = DSCR_STATE_W,
    parameter int unsigned WORD_W  = DSCR_WORD_W,
    parameter logic [STATE_W-1:0] SEED = DSCR_SEED,
    parameter logic [STATE_W-1:0] TAPS = DSCR_TAPS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              advance,
    output logic [WORD_W-1:0] mask
);
    localparam int unsigned SEQ_W = STATE_W + WORD_W;

    typedef struct packed {
        logic [STATE_W-1:0] hist;
    } gen_t;

    gen_t gen_d, gen_q;

    // unroll WORD_W steps of the recurrence from the stored history
    function automatic logic [WORD_W-1:0] expand(input logic [STATE_W-1:0] h);
        logic [SEQ_W-1:0] seq;
        seq = '0;
        seq[STATE_W-1:0] = h;
        for (int k = 0; k < WORD_W; k++) begin
            seq[STATE_W+k] = ^(seq[k +: STATE_W] & TAPS);
        end
        return seq[STATE_W +: WORD_W];
    endfunction

    always_comb begin
        gen_d = gen_q;
        mask  = expand(gen_q.hist);
        if (restart) begin
            gen_d.hist = SEED;
        end else if (advance) begin
            gen_d.hist = mask[WORD_W-1 -: STATE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q.hist <= SEED;
        end else begin
            gen_q <= gen_d;
        end
    end
endmodule

// File: rtl/dscr_out_stage.sv
module dscr_out_stage
    import dscr_pkg::*;
#(
    parameter int unsigned WORD_W = DSCR_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] mask,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              accept,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data
);
    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] data;
    } stage_t;

    stage_t stg_d, stg_q;

    always_comb begin
        stg_d    = stg_q;
        in_ready = out_ready || !stg_q.valid;
        accept   = in_valid && in_ready;
        if (accept) begin
            stg_d.valid = 1'b1;
            stg_d.data  = in_data ^ mask;
        end else if (out_ready) begin
            stg_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign out_valid = stg_q.valid;
    assign out_data  = stg_q.data;
endmodule

// File: rtl/dword_scrambler.sv
module dword_scrambler
    import dscr_pkg::*;
#(
    parameter int unsigned STATE_W = DSCR_STATE_W,
    parameter int unsigned WORD_W  = DSCR_WORD_W,
    parameter logic [STATE_W-1:0] SEED = DSCR_SEED,
    parameter logic [STATE_W-1:0] TAPS = DSCR_TAPS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data
);
    logic [WORD_W-1:0] mask_w;
    logic              accept_w;

    dscr_mask_gen #(
        .STATE_W(STATE_W), .WORD_W(WORD_W), .SEED(SEED), .TAPS(TAPS)
    ) u_mask (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .advance(accept_w), .mask(mask_w)
    );

    dscr_out_stage #(
        .WORD_W(WORD_W)
    ) u_stage (
        .clk(clk), .rst_n(rst_n), .mask(mask_w),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .accept(accept_w), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );
endmodule

// File: rtl/dword_scrambler_chk.sv
module dword_scrambler_chk #(
    parameter int unsigned WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              restart,
    input logic              in_valid,
    input logic              in_ready,
    input logic [WORD_W-1:0] in_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input logic [WORD_W-1:0] mask_w,
    input logic              accept_w
);
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R6
    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready); // R6
    AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready); // R8
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid && out_data == ($past(in_data) ^ $past(mask_w))); // R8
    AST_IDLE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_w && !restart |=> $stable(mask_w)); // R7
    AST_RESTART_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> mask_w == 32'hC2D2768D); // R5
endmodule

bind dword_scrambler dword_scrambler_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .restart(restart), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .mask_w(mask_w),
    .accept_w(accept_w)
);

// File: tb/dword_scrambler_bench.sv
module dword_scrambler_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dword_scrambler u_dword_scrambler (
        .clk(clk), .rst_n(rst_n), .restart(restart), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    localparam logic [31:0] STIM [8] = '{
        32'h00000000, 32'hFFFFFFFF, 32'h12345678, 32'hA5A5A5A5,
        32'h0000FFFF, 32'hDEADBEEF, 32'h80000001, 32'h3C3C3C3C
    };

    // bit-serial reference: one recurrence bit per step, 32 steps per word
    logic [15:0] ref_hist;
    function automatic logic [31:0] serial_word(inout logic [15:0] h);
        logic [31:0] w;
        logic        b;
        for (int i = 0; i < 32; i++) begin
            b    = h[15] ^ h[13] ^ h[4] ^ h[0];
            w[i] = b;
            h    = {b, h[15:1]};
        end
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // single word through a free-flowing sink; sample after the edge
    task automatic send(input logic [31:0] w, output logic [31:0] got);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        @(negedge clk);
        in_valid = 1'b0;
        got = out_data;
    endtask

    task automatic do_restart();
        @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] got, first, m, m0;
        logic [31:0] scr [8];
        int hits;

        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 in_ready after reset", {31'd0, in_ready}, 32'd1);
        check("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);

        // R2 / R3: table walk against the serial model
        ref_hist = 16'hF0F6;
        for (int i = 0; i < 8; i++) begin
            m = serial_word(ref_hist);
            if (i == 0) begin
                check("R2 model head", m, 32'hC2D2768D);
                m0 = m;
            end
            send(STIM[i], got);
            check(i == 0 ? "R2 first word" : "R3 table word", got, STIM[i] ^ m);
        end

        // R5: restart cycle word uses current mask, next uses head
        @(negedge clk);
        restart  = 1'b1;
        in_valid = 1'b1;
        in_data  = 32'h11112222;
        m = serial_word(ref_hist);
        @(negedge clk);
        restart  = 1'b0;
        in_valid = 1'b0;
        check("R5 word in restart cycle", out_data, 32'h11112222 ^ m);
        send(32'h0, got);
        check("R5 head after restart", got, 32'hC2D2768D);

        // R7: idle gap does not consume a mask
        ref_hist = 16'hF0F6;
        m = serial_word(ref_hist);
        m = serial_word(ref_hist);
        repeat (5) @(negedge clk);
        send(32'h0F0F0F0F, got);
        check("R7 after idle gap", got, 32'h0F0F0F0F ^ m);

        // R6: stall holds output and blocks input
        do_restart();
        ref_hist = 16'hF0F6;
        @(negedge clk);
        out_ready = 1'b0;
        in_valid  = 1'b1;
        in_data   = 32'hCAFEF00D;
        @(negedge clk);
        in_data   = 32'h55AA55AA;
        check("R6 ready low while full", {31'd0, in_ready}, 32'd0);
        repeat (3) @(negedge clk);
        m = serial_word(ref_hist);
        check("R6 held data", out_data, 32'hCAFEF00D ^ m);
        check("R6 held valid", {31'd0, out_valid}, 32'd1);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        m = serial_word(ref_hist);
        check("R6 next word after stall", out_data, 32'h55AA55AA ^ m);
        @(negedge clk);
        check("R8 drains to empty", {31'd0, out_valid}, 32'd0);

        // R9: scramble then descramble
        do_restart();
        for (int i = 0; i < 8; i++) begin
            send(STIM[i], got);
            scr[i] = got;
        end
        do_restart();
        for (int i = 0; i < 8; i++) begin
            send(scr[i], got);
            check("R9 round trip", got, STIM[i]);
        end

        // R4 / R8: continuous flow, period of 65535 words
        do_restart();
        hits = 0;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 32'h0;
        for (int i = 0; i <= 65535; i++) begin
            @(negedge clk);
            if (i == 0) begin
                first = out_data;
                check("R8 back-to-back first", first, m0);
            end else if (i == 65535) begin
                check("R4 wrap to head", out_data, first);
            end else if (out_data == first) begin
                hits++;
            end
        end
        in_valid = 1'b0;
        check("R4 early repeats", hits, 0);

        finish_run();
    end
endmodule